// File: doc/BRIEF.md
# CSR Access Checker with Read-Modify-Write

This block carries out a single control-register instruction against a small register file. Each request supplies a 12-bit register address, one of four operation kinds (read, write, bit-set, bit-clear), a data operand and the privilege level the request runs at. The block decides if the access is allowed and merges the operand into the addressed register under a write mask. It returns the value the register held before the access, or it raises an illegal-instruction flag.

Two address fields set the access rules. Bits [9:8] give the lowest privilege that may reach the register. Bits [11:10] equal to 2'b11 mark the register as read-only. The user counters have a further gate: two enable registers, one owned by machine level and one by supervisor level, are applied in turn. The register set holds the two enable registers, a scratch register and a trap vector register for each of machine and supervisor level, a free-running cycle counter, a counter of accesses that completed legally, and a constant hart identifier.

Each request takes one clock. The response is registered and appears one cycle after the request.

Top module: `csr_access_unit`

## Requirements
- R1: An access whose privilege (encoded U=0, S=1, M=3) is numerically below address bits [9:8] is illegal.
- R2: An access to an address with bits [11:10]=2'b11 is illegal if its write mask is nonzero. A read, or a set or clear with a zero operand, stays legal.
- R3: Operation codes on `req_op` are 0 read (mask 0), 1 write (new value = operand, mask all ones), 2 set (new value all ones, mask = operand) and 3 clear (new value 0, mask = operand).
- R4: A legal access returns the register's old value. The register becomes (old & ~mask) | (new & mask), and only when the mask is nonzero.
- R5: The user counters sit at 0xC00 (cycles) and 0xC02 (legal accesses). A counter needs bit addr[4:0] of an enable that starts as all ones. Below M the enable is ANDed with the machine counter-enable register (0x306). Below S it is also ANDed with the supervisor counter-enable register (0x106). A clear bit makes the access illegal.
- R6: Only 0x306, 0x106, 0x340 (machine scratch), 0x140 (supervisor scratch), 0x305 (machine trap vector), 0x105 (supervisor trap vector), 0xC00, 0xC02 and 0xF14 (hart id) exist. Any other address is illegal.
- R7: A trap vector register takes a write only if the merged value's bits [1:0] are 0 or 1. Otherwise the write is dropped and the access is still legal.
- R8: An illegal access changes no register, returns 0 as data, and asserts `rsp_illegal` for exactly one cycle.
- R9: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. After reset both response flags are low and every register reads 0.
- R10: The cycle counter goes up by one every clock. The access counter goes up by one after each legal access, and a read of it returns the count before that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Register address |
| req_op | input | 2 | Operation code (R3) |
| req_operand | input | XLEN | Data operand |
| req_priv | input | 2 | Privilege of the request |
| rsp_valid | output | 1 | Response present |
| rsp_illegal | output | 1 | Access was refused |
| rsp_rdata | output | XLEN | Old register value, 0 when illegal |

## Verification
The bench goes after these corner cases:
- **Set or clear with a zero operand on a read-only counter.** This must stay legal. A design that judged read-only access by the operation kind would trap here.
- **The two-stage counter gate.** The bench changes each enable in turn and reads the counters from U, S and M. Applying the supervisor enable at supervisor level, or skipping the machine enable, shows up as the wrong flag.
- **Trap vector writes with mode bits 2 or 3.** These must be dropped without a trap. The bench reads the register back afterwards.
- **Refused accesses.** A refused access followed by a read-back exposes any leaked write or a leaked increment of the access counter.
- **Random mixes.** These compare every returned old value against a bench model.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int NUM_CSR  = 9;
  localparam int CNT_EN_W = 32;

  localparam int IX_MCEN  = 0;
  localparam int IX_SCEN  = 1;
  localparam int IX_MSCR  = 2;
  localparam int IX_SSCR  = 3;
  localparam int IX_MTVEC = 4;
  localparam int IX_STVEC = 5;
  localparam int IX_UCYC  = 6;
  localparam int IX_URET  = 7;
  localparam int IX_HART  = 8;

  localparam logic [11:0] CSR_MAP [NUM_CSR] = '{
    12'h306, 12'h106, 12'h340, 12'h140, 12'h305,
    12'h105, 12'hC00, 12'hC02, 12'hF14
  };

  localparam logic [6:0] UCNT_PAGE = 7'h60;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_unit_pkg::*;
#(
  parameter int N = NUM_CSR
) (
  input  logic [11:0]  addr,
  output logic [N-1:0] sel,
  output logic         hit,
  output logic [1:0]   min_priv,
  output logic         read_only,
  output logic         is_ucnt
);
  for (genvar g = 0; g < N; g++) begin : g_match
    assign sel[g] = (addr == CSR_MAP[g]);
  end

  assign hit       = |sel;
  assign min_priv  = addr[9:8];
  assign read_only = (addr[11:10] == 2'b11);
  assign is_ucnt   = (addr[11:5] == UCNT_PAGE);
endmodule

// File: rtl/csr_ctr_gate.sv
module csr_ctr_gate
  import csr_unit_pkg::*;
#(
  parameter int W = CNT_EN_W,
  localparam int IW = $clog2(W)
) (
  input  logic [1:0]    priv,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  m_en,
  input  logic [W-1:0]  s_en,
  output logic          ok
);
  logic [W-1:0] en;

  always_comb begin
    en = '1;
    if (priv < PRIV_M) en = en & m_en;
    if (priv < PRIV_S) en = en & s_en;
    ok = en[idx];
  end
endmodule

// File: rtl/csr_mask_merge.sv
module csr_mask_merge
  import csr_unit_pkg::*;
#(
  parameter int W = 32
) (
  input  csr_op_e      op,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] old_val,
  output logic [W-1:0] merged,
  output logic         wr_any
);
  logic [W-1:0] mask;
  logic [W-1:0] nval;

  always_comb begin
    unique case (op)
      OP_READ:  begin mask = '0;      nval = '0;      end
      OP_WRITE: begin mask = '1;      nval = operand; end
      OP_SET:   begin mask = operand; nval = '1;      end
      default:  begin mask = operand; nval = '0;      end
    endcase
    merged = (old_val & ~mask) | (nval & mask);
    wr_any = |mask;
  end
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
  import csr_unit_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] HART_ID = 32'd0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [11:0]     req_addr,
  input  logic [1:0]      req_op,
  input  logic [XLEN-1:0] req_operand,
  input  logic [1:0]      req_priv,
  output logic            rsp_valid,
  output logic            rsp_illegal,
  output logic [XLEN-1:0] rsp_rdata
);
  localparam int IW = $clog2(CNT_EN_W);

  csr_op_e op_e;
  assign op_e = csr_op_e'(req_op);

  logic [NUM_CSR-1:0] sel;
  logic               hit, read_only, is_ucnt, ctr_ok, wr_any;
  logic [1:0]         min_priv;
  logic [XLEN-1:0]    old_val, merged;

  logic [XLEN-1:0] mcen_q, scen_q, mscr_q, sscr_q, mtvec_q, stvec_q, cyc_q, ret_q;
  logic [XLEN-1:0] rv [NUM_CSR];

  csr_addr_decode #(.N(NUM_CSR)) u_dec (
    .addr(req_addr), .sel(sel), .hit(hit), .min_priv(min_priv),
    .read_only(read_only), .is_ucnt(is_ucnt)
  );

  csr_ctr_gate #(.W(CNT_EN_W)) u_gate (
    .priv(req_priv), .idx(req_addr[IW-1:0]),
    .m_en(mcen_q[CNT_EN_W-1:0]), .s_en(scen_q[CNT_EN_W-1:0]), .ok(ctr_ok)
  );

  csr_mask_merge #(.W(XLEN)) u_merge (
    .op(op_e), .operand(req_operand), .old_val(old_val),
    .merged(merged), .wr_any(wr_any)
  );

  assign rv[IX_MCEN]  = mcen_q;
  assign rv[IX_SCEN]  = scen_q;
  assign rv[IX_MSCR]  = mscr_q;
  assign rv[IX_SSCR]  = sscr_q;
  assign rv[IX_MTVEC] = mtvec_q;
  assign rv[IX_STVEC] = stvec_q;
  assign rv[IX_UCYC]  = cyc_q;
  assign rv[IX_URET]  = ret_q;
  assign rv[IX_HART]  = XLEN'(HART_ID);

  always_comb begin
    old_val = '0;
    for (int i = 0; i < NUM_CSR; i++)
      if (sel[i]) old_val = old_val | rv[i];
  end

  logic legal, wr_go, mode_ok;
  assign legal   = req_valid && hit && (req_priv >= min_priv)
                   && !(read_only && wr_any) && (!is_ucnt || ctr_ok);
  assign wr_go   = legal && wr_any;
  assign mode_ok = (merged[1:0] < 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      mcen_q <= '0; scen_q <= '0; mscr_q <= '0; sscr_q <= '0;
      mtvec_q <= '0; stvec_q <= '0; cyc_q <= '0; ret_q <= '0;
      rsp_valid <= 1'b0; rsp_illegal <= 1'b0; rsp_rdata <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (legal) ret_q <= ret_q + 1'b1;
      if (wr_go && sel[IX_MCEN]) mcen_q <= merged;
      if (wr_go && sel[IX_SCEN]) scen_q <= merged;
      if (wr_go && sel[IX_MSCR]) mscr_q <= merged;
      if (wr_go && sel[IX_SSCR]) sscr_q <= merged;
      if (wr_go && sel[IX_MTVEC] && mode_ok) mtvec_q <= merged;
      if (wr_go && sel[IX_STVEC] && mode_ok) stvec_q <= merged;
      rsp_valid   <= req_valid;
      rsp_illegal <= req_valid && !legal;
      rsp_rdata   <= legal ? old_val : '0;
    end
  end

  // R8: a refused access leaves every writable register as it was
  a_r8_illegal_keeps_state: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> ($stable(mcen_q) && $stable(scen_q) && $stable(mscr_q)
                     && $stable(sscr_q) && $stable(mtvec_q) && $stable(stvec_q)
                     && $stable(ret_q)));

  // R7: trap vector mode field never holds a reserved value
  a_r7_tvec_mode_legal: assert property (@(posedge clk) disable iff (rst)
    (mtvec_q[1] == 1'b0) && (stvec_q[1] == 1'b0));

  // R9: responses only follow requests
  a_r9_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));

  a_r9_illegal_in_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> rsp_valid);

  // R2: a granted access to a read-only address carried a zero mask
  a_r2_ro_granted_no_mask: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_illegal && ($past(req_addr[11:10]) == 2'b11))
      |-> ($past(req_op) == 2'd0 || $past(req_operand) == '0));

  // R10: the access counter never steps by more than one
  a_r10_ret_step: assert property (@(posedge clk) disable iff (rst)
    (ret_q == $past(ret_q)) || (ret_q == $past(ret_q) + 1'b1));
endmodule

// File: tb/csr_access_unit_test.sv
module csr_access_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam logic [31:0] HID = 32'h0000_002A;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0] req_op = '0;
  logic [XLEN-1:0] req_operand = '0;
  logic [1:0] req_priv = '0;
  logic rsp_valid, rsp_illegal;
  logic [XLEN-1:0] rsp_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] m_mcen = 0, m_scen = 0, m_mscr = 0, m_sscr = 0;
  logic [31:0] m_mtvec = 0, m_stvec = 0, m_ret = 0;
  logic [31:0] last_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_access_unit #(.XLEN(XLEN), .HART_ID(HID)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .req_operand(req_operand), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected outcome from the requirements; updates the model state.
  task automatic model(input logic [11:0] a, input logic [1:0] op, input logic [31:0] opd,
                       input logic [1:0] pr, output bit legal, output logic [31:0] old);
    bit exists = 1;
    logic [31:0] mask, nv, mg, en;
    case (a)
      12'h306: old = m_mcen;  12'h106: old = m_scen;
      12'h340: old = m_mscr;  12'h140: old = m_sscr;
      12'h305: old = m_mtvec; 12'h105: old = m_stvec;
      12'hC00: old = 0;       12'hC02: old = m_ret;
      12'hF14: old = HID;
      default: begin old = 0; exists = 0; end
    endcase
    case (op)
      2'd0: begin mask = 0; nv = 0; end
      2'd1: begin mask = '1; nv = opd; end
      2'd2: begin mask = opd; nv = '1; end
      default: begin mask = opd; nv = 0; end
    endcase
    en = '1;
    if (pr != PM) en &= m_mcen;
    if (pr == PU) en &= m_scen;
    legal = exists && (pr >= a[9:8]) && !((a[11:10] == 2'b11) && (mask != 0))
            && !((a[11:5] == 7'h60) && !en[a[4:0]]);
    mg = (old & ~mask) | (nv & mask);
    if (legal && mask != 0) begin
      case (a)
        12'h306: m_mcen = mg;
        12'h106: m_scen = mg;
        12'h340: m_mscr = mg;
        12'h140: m_sscr = mg;
        12'h305: if (mg[1:0] < 2) m_mtvec = mg;
        12'h105: if (mg[1:0] < 2) m_stvec = mg;
        default: ;
      endcase
    end
    if (legal) m_ret = m_ret + 1;
    if (!legal) old = 0;
  endtask

  // Drive at a falling edge, sample at the next falling edge (one register stage).
  task automatic acc(input string tag, input logic [11:0] a, input logic [1:0] op,
                     input logic [31:0] opd, input logic [1:0] pr);
    bit legal;
    logic [31:0] old;
    model(a, op, opd, pr, legal, old);
    req_valid = 1; req_addr = a; req_op = op; req_operand = opd; req_priv = pr;
    @(negedge clk);
    check({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    check({tag, " illegal"}, {31'd0, rsp_illegal}, {31'd0, !legal});
    if (!(a == 12'hC00 && legal)) check({tag, " rdata"}, rsp_rdata, old);
    last_rd = rsp_rdata;
  endtask

  task automatic idle();
    req_valid = 0;
    @(negedge clk);
    check("R8 R9 idle valid", {31'd0, rsp_valid}, 32'd0);
    check("R8 idle illegal", {31'd0, rsp_illegal}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] c0;
    logic [11:0] pool [12];
    logic [1:0] prs [3];
    int unsigned seed;
    pool = '{12'h306, 12'h106, 12'h340, 12'h140, 12'h305, 12'h105,
             12'hC00, 12'hC02, 12'hF14, 12'h341, 12'hC01, 12'h7C0};
    prs = '{PU, PS, PM};
    seed = $urandom(32'h5EED);

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 reset valid", {31'd0, rsp_valid}, 32'd0);
    check("R9 reset illegal", {31'd0, rsp_illegal}, 32'd0);

    acc("R9 R4 reset read", 12'h340, 2'd0, 32'h0, PM);
    acc("R3 write", 12'h340, 2'd1, 32'hA5A5_0F0F, PM);
    acc("R3 set", 12'h340, 2'd2, 32'h0000_00F0, PM);
    acc("R3 clear", 12'h340, 2'd3, 32'hA000_0000, PM);
    acc("R4 readback", 12'h340, 2'd0, 32'hFFFF_FFFF, PM);
    acc("R1 S to M reg", 12'h340, 2'd1, 32'h1111_1111, PS);
    acc("R8 unchanged", 12'h340, 2'd0, 32'h0, PM);
    acc("R1 U to S reg", 12'h140, 2'd0, 32'h0, PU);
    acc("R1 S to S reg", 12'h140, 2'd1, 32'h0000_1234, PS);
    acc("R4 zero-mask set", 12'h140, 2'd2, 32'h0, PS);
    acc("R2 write ro", 12'hC00, 2'd1, 32'h5, PM);
    acc("R2 set zero ro", 12'hC02, 2'd2, 32'h0, PM);
    acc("R2 clear ro", 12'hF14, 2'd3, 32'h5, PM);
    acc("R2 hart read", 12'hF14, 2'd0, 32'h0, PM);
    acc("R5 U no enable", 12'hC00, 2'd0, 32'h0, PU);
    acc("R5 S no enable", 12'hC00, 2'd0, 32'h0, PS);
    acc("R5 M always", 12'hC00, 2'd0, 32'h0, PM);
    acc("R5 set m_en", 12'h306, 2'd1, 32'h1, PM);
    acc("R5 S after m_en", 12'hC00, 2'd0, 32'h0, PS);
    acc("R5 U needs s_en", 12'hC00, 2'd0, 32'h0, PU);
    acc("R5 set s_en", 12'h106, 2'd1, 32'h1, PS);
    acc("R5 U both en", 12'hC00, 2'd0, 32'h0, PU);
    acc("R5 U bit2 off", 12'hC02, 2'd0, 32'h0, PU);
    acc("R5 m_en bit2", 12'h306, 2'd2, 32'h4, PM);
    acc("R5 s_en bit2", 12'h106, 2'd2, 32'h4, PS);
    acc("R5 R10 U retired", 12'hC02, 2'd0, 32'h0, PU);
    acc("R6 missing", 12'h341, 2'd0, 32'h0, PM);
    acc("R6 gap counter", 12'hC01, 2'd0, 32'h0, PM);
    acc("R7 mode2 drop", 12'h305, 2'd1, 32'h1000_0002, PM);
    acc("R7 readback", 12'h305, 2'd0, 32'h0, PM);
    acc("R7 mode1 write", 12'h305, 2'd1, 32'h1000_0001, PM);
    acc("R7 readback2", 12'h305, 2'd0, 32'h0, PM);
    acc("R7 set mode3", 12'h105, 2'd2, 32'h3, PS);
    acc("R7 s readback", 12'h105, 2'd0, 32'h0, PS);
    acc("R10 cycle a", 12'hC00, 2'd0, 32'h0, PM);
    c0 = last_rd;
    acc("R10 cycle b", 12'hC00, 2'd0, 32'h0, PM);
    check("R10 cycle step", last_rd - c0, 32'd1);
    idle();

    for (int i = 0; i < 400; i++) begin
      logic [31:0] opd;
      opd = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      if ($urandom % 3 == 0) opd[1:0] = 2'($urandom);
      acc("R1 R3 R4 R5 random", pool[$urandom % 12], 2'($urandom), opd, prs[$urandom % 3]);
      if (i % 50 == 49) idle();
    end
    idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule